// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Model

This block is a synthesizable logical model of an asynchronous static memory with two independent byte lanes. It has active-low chip select, output enable, write strobe and one enable per byte lane. The word is 16 bits wide: lane 0 holds bits 7:0 and lane 1 holds bits 15:8. All control, address and data pins are sampled on a fast internal clock that stands in for continuous time. The model then decodes the control combination into a read, a write, an output-disabled state or standby. Each lane is handled on its own.

The bidirectional bus is split into three parts at the module boundary: `data_in` carries write data, `data_out` carries read data and `data_oe` is a per-lane drive flag. A surrounding testbench or pad wrapper can therefore check high impedance without tri-state logic. A lane's write window is open while chip select, write strobe and that lane's enable are all low. The lane keeps the most recent sampled bus value while its window is open and stores it in the cycle the window closes. The window closes when the first of the three signals goes high. The address width is a parameter. Set to 15, it gives the full 32,768-word array; the default is smaller so the model stays light to elaborate.

Top module: `bls_sram`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits, and every word is separately addressable. ADDR_W=15 gives 32,768 words. Outputs reflect inputs sampled at the previous clock edge.
- R2: With cs_n=0, oe_n=0 and we_n=1, each lane whose enable is low (lane_en_n[0] is lane 0, bits 7:0; lane_en_n[1] is lane 1, bits 15:8) has data_oe set and presents the stored byte on its data_out bits.
- R3: A lane that is not being read has data_oe clear and zero on its data_out bits. This applies when output enable is high, when the lane's enable is high, or when chip select is high.
- R4: A write (cs_n=0, we_n=0) stores a lane only when that lane's enable is low. A lane whose enable is high keeps its old contents.
- R5: While any lane's write window is open, data_oe is 00 even if oe_n is low.
- R6: The stored value is the data_in sampled in the last cycle the lane's window was open. Data changes earlier in the window are overwritten.
- R7: A window closes on the first of chip select, write strobe or the lane enable going high. Each lane closes and commits on its own, so the two lanes of one word can store data from different cycles.
- R8: standby equals the sampled cs_n. While standby is high no lane drives, and no write takes place whatever the other inputs are.
- R9: When chip select and write strobe rise in the same cycle with oe_n low, data_oe stays 00 in that cycle.
- R10: A read of the same address in the cycle right after a window closes returns the newly written byte.
- R11: After reset, standby is 1, data_oe is 00 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| lane_en_n | input | 2 | Per-lane enable, active low; bit 0 is bits 7:0 |
| addr | input | ADDR_W | Word address |
| data_in | input | 16 | Bus value driven toward the memory |
| data_out | output | 16 | Read data, zero in undriven lanes |
| data_oe | output | 2 | Per-lane output drive flag |
| standby | output | 1 | Deselected power-down indication |

## Verification
The read path is tried with both lanes, each lane alone, output enable high and both lane enables high. These patterns separate correct lane steering from whole-word behaviour and from stray drive. Writes are closed in turn by the write strobe, by chip select and by a lane enable, and one case drops a single lane in mid-window. Only per-lane commit gives a word mixing bytes from two cycles. A window whose data changes partway through shows whether the first or the last sample is kept. Writes attempted while deselected, a simultaneous rise of chip select and write strobe, and a read right after a write together check the standby gating, the absence of glitches and the commit bypass.

// File: rtl/bls_pkg.sv
package bls_pkg;
  // Read decode: selected, outputs enabled, not writing.
  function automatic logic f_read_sel(input logic cs_n, input logic oe_n, input logic we_n);
    return !cs_n && !oe_n && we_n;
  endfunction

  // Write decode: selected and write strobe low (lane enable applied per lane).
  function automatic logic f_write_sel(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  // Lane slice of a word.
  function automatic logic [7:0] f_lane(input logic [15:0] w, input int idx);
    return w[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/bls_sampler.sv
module bls_sampler #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic              cs_n_s,
  output logic              oe_n_s,
  output logic              we_n_s,
  output logic [LANES-1:0]  lane_en_n_s,
  output logic [ADDR_W-1:0] addr_s,
  output logic [DATA_W-1:0] data_s
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_s      <= 1'b1;
      oe_n_s      <= 1'b1;
      we_n_s      <= 1'b1;
      lane_en_n_s <= '1;
      addr_s      <= '0;
      data_s      <= '0;
    end else begin
      cs_n_s      <= cs_n;
      oe_n_s      <= oe_n;
      we_n_s      <= we_n;
      lane_en_n_s <= lane_en_n;
      addr_s      <= addr;
      data_s      <= data_in;
    end
  end
endmodule

// File: rtl/bls_lane.sv
module bls_lane #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_sel,
  input  logic              wr_sel,
  input  logic              lane_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout,
  output logic              drive,
  output logic              win_open,
  output logic              commit
);
  logic [LANE_W-1:0] mem [DEPTH];
  logic              open_q;
  logic [ADDR_W-1:0] a_hold;
  logic [LANE_W-1:0] d_hold;
  logic              fwd_hit;

  assign win_open = wr_sel && lane_en;
  assign commit   = open_q && !win_open;
  assign drive    = rd_sel && lane_en;
  assign fwd_hit  = commit && (a_hold == addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      a_hold <= '0;
      d_hold <= '0;
    end else begin
      open_q <= win_open;
      if (win_open) begin
        a_hold <= addr;
        d_hold <= din;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[a_hold] <= d_hold;
  end

  always_comb begin
    if (!drive)       dout = '0;
    else if (fwd_hit) dout = d_hold;
    else              dout = mem[addr];
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (dout == '0)); // R3
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R6
  AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (mem[$past(a_hold)] == $past(d_hold))); // R6
endmodule

// File: rtl/bls_sram.sv
module bls_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic [LANES-1:0]  data_oe,
  output logic              standby
);
  import bls_pkg::*;

  logic              cs_n_s, oe_n_s, we_n_s;
  logic [LANES-1:0]  lane_en_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              rd_sel, wr_sel;
  logic [LANES-1:0]  lane_open, lane_commit;

  bls_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .lane_en_n(lane_en_n), .addr(addr), .data_in(data_in),
    .cs_n_s(cs_n_s), .oe_n_s(oe_n_s), .we_n_s(we_n_s),
    .lane_en_n_s(lane_en_n_s), .addr_s(addr_s), .data_s(data_s)
  );

  assign rd_sel  = f_read_sel(cs_n_s, oe_n_s, we_n_s);
  assign wr_sel  = f_write_sel(cs_n_s, we_n_s);
  assign standby = cs_n_s;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bls_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
      .lane_en(!lane_en_n_s[g]), .addr(addr_s),
      .din(data_s[g*LANE_W +: LANE_W]),
      .dout(data_out[g*LANE_W +: LANE_W]),
      .drive(data_oe[g]), .win_open(lane_open[g]), .commit(lane_commit[g])
    );
  end

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_open) |-> (data_oe == '0)); // R5
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (data_oe == '0 && lane_open == '0)); // R8
  AST_RISE_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && $past(|lane_open)) |-> (data_oe == '0)); // R9
  AST_DRIVE_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_oe) |-> (!cs_n_s && !oe_n_s && we_n_s)); // R2
endmodule

// File: tb/bls_sram_bench.sv
`timescale 1ns/1ps
module bls_sram_bench;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [1:0]  lane_en_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic [1:0]  data_oe;
  logic        standby;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bls_sram #(.ADDR_W(AW)) u_bls_sram (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .lane_en_n(lane_en_n), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .standby(standby)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic c, input logic o, input logic w, input logic [1:0] b,
                     input logic [AW-1:0] a, input logic [15:0] d);
    cs_n = c; oe_n = o; we_n = w; lane_en_n = b; addr = a; data_in = d;
  endtask

  task automatic idle();
    drv(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] b);
    drv(1'b0, 1'b1, 1'b0, b, a, d);
    tick();
    idle();
    tick(2);
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [1:0] b,
                        input logic [1:0] exp_oe, input logic [15:0] exp_d);
    drv(1'b0, 1'b0, 1'b1, b, a, '0);
    tick();
    check({req, " oe"}, {30'd0, data_oe}, {30'd0, exp_oe});
    check({req, " data"}, {16'd0, data_out}, {16'd0, exp_d});
    idle();
    tick();
  endtask

  task automatic t_reset();
    check("R11 standby", {31'd0, standby}, 32'd1);
    check("R11 oe", {30'd0, data_oe}, 32'd0);
  endtask

  task automatic t_basic();
    wr(10'h010, 16'hA5C3, 2'b00);
    rd_chk("R2 full read", 10'h010, 2'b00, 2'b11, 16'hA5C3);
    wr(10'h010, 16'h7E11, 2'b01);
    rd_chk("R4 upper only write", 10'h010, 2'b00, 2'b11, 16'h7EC3);
    rd_chk("R2 lower lane read", 10'h010, 2'b10, 2'b01, 16'h00C3);
    rd_chk("R3 upper lane read", 10'h010, 2'b01, 2'b10, 16'h7E00);
    rd_chk("R3 both lanes off", 10'h010, 2'b11, 2'b00, 16'h0000);
    drv(1'b0, 1'b1, 1'b1, 2'b00, 10'h010, '0);
    tick();
    check("R3 oe high", {14'd0, data_oe, data_out}, 32'd0);
    idle(); tick();
  endtask

  task automatic t_range();
    wr(10'h000, 16'h1234, 2'b00);
    wr(10'h3FF, 16'hFEDC, 2'b00);
    rd_chk("R1 low word", 10'h000, 2'b00, 2'b11, 16'h1234);
    rd_chk("R1 top word", 10'h3FF, 2'b00, 2'b11, 16'hFEDC);
  endtask

  task automatic t_deselect();
    drv(1'b1, 1'b0, 1'b0, 2'b00, 10'h010, 16'hFFFF);
    tick();
    check("R8 standby", {31'd0, standby}, 32'd1);
    check("R8 no drive", {30'd0, data_oe}, 32'd0);
    idle(); tick(2);
    rd_chk("R8 no write while deselected", 10'h010, 2'b00, 2'b11, 16'h7EC3);
  endtask

  task automatic t_window();
    drv(1'b0, 1'b0, 1'b0, 2'b00, 10'h020, 16'h1111);
    tick();
    check("R5 quiet in write", {30'd0, data_oe}, 32'd0);
    drv(1'b0, 1'b0, 1'b0, 2'b00, 10'h020, 16'h2222);
    tick();
    idle(); tick(2);
    rd_chk("R6 last data kept", 10'h020, 2'b00, 2'b11, 16'h2222);
    // closed by chip select, write strobe held low
    drv(1'b0, 1'b1, 1'b0, 2'b00, 10'h030, 16'h3333);
    tick();
    drv(1'b1, 1'b1, 1'b0, 2'b00, 10'h030, 16'h9999);
    tick(2);
    idle(); tick();
    rd_chk("R7 closed by select", 10'h030, 2'b00, 2'b11, 16'h3333);
    // closed by lane enables
    drv(1'b0, 1'b1, 1'b0, 2'b00, 10'h031, 16'h4444);
    tick();
    drv(1'b0, 1'b1, 1'b0, 2'b11, 10'h031, 16'h8888);
    tick(2);
    idle(); tick();
    rd_chk("R7 closed by lane enable", 10'h031, 2'b00, 2'b11, 16'h4444);
    // upper lane drops early, lower continues with new data
    drv(1'b0, 1'b1, 1'b0, 2'b00, 10'h040, 16'hAABB);
    tick();
    drv(1'b0, 1'b1, 1'b0, 2'b10, 10'h040, 16'hCCDD);
    tick();
    idle(); tick(2);
    rd_chk("R7 per lane close", 10'h040, 2'b00, 2'b11, 16'hAADD);
  endtask

  task automatic t_rise_together();
    drv(1'b0, 1'b0, 1'b0, 2'b00, 10'h050, 16'h5A5A);
    tick();
    drv(1'b1, 1'b0, 1'b1, 2'b00, 10'h050, 16'h0000);
    tick();
    check("R9 no glitch", {30'd0, data_oe}, 32'd0);
    check("R9 standby", {31'd0, standby}, 32'd1);
    idle(); tick();
    rd_chk("R9 data stored", 10'h050, 2'b00, 2'b11, 16'h5A5A);
  endtask

  task automatic t_forward();
    drv(1'b0, 1'b1, 1'b0, 2'b00, 10'h060, 16'hBEEF);
    tick();
    drv(1'b0, 1'b0, 1'b1, 2'b00, 10'h060, 16'h0000);
    tick();
    check("R10 read after write oe", {30'd0, data_oe}, 32'd3);
    check("R10 read after write data", {16'd0, data_out}, {16'd0, 16'hBEEF});
    idle(); tick();
    rd_chk("R10 later read", 10'h060, 2'b00, 2'b11, 16'hBEEF);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_range();
    t_deselect();
    t_window();
    t_rise_together();
    t_forward();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule